// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is a clocked lock controller that compares a sequence of three user-entered digits against three stored code digits. A one-hot selector picks the stored digit expected next. An equality comparator made of per-bit XNORs checks that digit against the entered value. Each enter strobe either moves the controller forward or sends it to a fault state. If all three digits match in order, the lock drives its open output.

The state register is one-hot for the three digit positions and the open position, and an all-zero value means error. Because of this encoding, the low three state bits act directly as the digit selector and the top bit acts directly as the open output, so neither needs decoding. The open and error states can only be left through reset. All inputs are assumed to be synchronous to the clock.

Top module: `combo_lock_top`

## Requirements
- R1: A synchronous active-high reset puts the controller in the first-digit state, whatever the other inputs are. In that state the state value is 4'b0001, `digit_sel` is 3'b001 and `unlocked` is 0.
- R2: In a digit state with `enter` low, the state stays the same on every clock edge.
- R3: In a digit state, an `enter` pulse with `entry` equal to the selected stored digit moves the state forward one step: 0001 to 0010, 0010 to 0100, 0100 to 1000 (open). The change takes effect at the next rising edge.
- R4: In a digit state, an `enter` pulse with `entry` different from the selected stored digit sends the controller to the error state 4'b0000.
- R5: `digit_sel` is one-hot and follows the digit position: 3'b001 for digit 1, 3'b010 for digit 2 and 3'b100 for digit 3. It is 3'b000 in the open and error states.
- R6: `unlocked` is 1 only in the open state.
- R7: The open and error states are absorbing. Enter pulses with any entry value leave them unchanged, and only reset exits them.
- R8: The equality check uses all bits of the entry. A value that differs from the stored digit in any single bit counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enter | input | 1 | One-cycle strobe that presents a digit |
| entry | input | 4 | Digit value entered by the user |
| code0 | input | 4 | Stored first code digit |
| code1 | input | 4 | Stored second code digit |
| code2 | input | 4 | Stored third code digit |
| digit_sel | output | 3 | One-hot selector of the expected digit |
| unlocked | output | 1 | High while the lock is open |

## Verification
The bench goes after the cases a plausible fault would break. It flips each entry bit on its own, which catches a comparator that ignores a bit. It gives a wrong third digit, which catches a controller that opens too early. It sends enter pulses while the lock is open or in error, which catches a design that lets the open state re-arm or lets the error state recover without reset. It idles between digits, which exposes any state that moves without a strobe. It also asserts reset together with enter and a matching digit, which catches a reset with lower priority than the strobe.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int DIGIT_W = 4;
  localparam int NUM_DIGITS = 3;
  localparam int STATE_W = NUM_DIGITS + 1;

  localparam logic [STATE_W-1:0] ST_D0   = 4'b0001;
  localparam logic [STATE_W-1:0] ST_D1   = 4'b0010;
  localparam logic [STATE_W-1:0] ST_D2   = 4'b0100;
  localparam logic [STATE_W-1:0] ST_OPEN = 4'b1000;
  localparam logic [STATE_W-1:0] ST_ERR  = 4'b0000;
endpackage

// File: rtl/digit_select.sv
module digit_select #(
  parameter int DW = 4,
  parameter int ND = 3
) (
  input  logic [ND-1:0]      sel,
  input  logic [ND*DW-1:0]   codes,
  output logic [DW-1:0]      picked
);
  logic [DW-1:0] masked [ND];

  for (genvar i = 0; i < ND; i++) begin : g_mask
    assign masked[i] = codes[i*DW +: DW] & {DW{sel[i]}};
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < ND; i++) picked = picked | masked[i];
  end

  always_comb begin
    // R5 selector must be one-hot or idle
    sel_onehot_chk: assert ($onehot0(sel) || $isunknown(sel));
  end
endmodule

// File: rtl/digit_compare.sv
module digit_compare #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          match
);
  logic [DW-1:0] bit_eq;

  for (genvar i = 0; i < DW; i++) begin : g_xnor
    assign bit_eq[i] = ~(a[i] ^ b[i]);
  end

  assign match = &bit_eq;
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import combo_lock_pkg::*;
#(
  parameter int ND = NUM_DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enter,
  input  logic         match,
  output logic [ND:0]  state
);
  logic [ND:0] state_nx;
  logic        in_digit;

  assign in_digit = |state[ND-1:0];

  always_comb begin
    state_nx = state;
    if (in_digit && enter) begin
      if (match) state_nx = state << 1;
      else       state_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= {{ND{1'b0}}, 1'b1};
    else     state <= state_nx;
  end

  // R1
  reset_init_chk: assert property (@(posedge clk) rst |=> state == {{ND{1'b0}}, 1'b1});
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_digit && !enter) |=> $stable(state));
  // R4
  mismatch_err_chk: assert property (@(posedge clk) disable iff (rst)
    (in_digit && enter && !match) |=> state == '0);
  // R7
  absorb_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_digit) |=> $stable(state));
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (in_digit && enter && match) |=> $countones(state) == 1);
endmodule

// File: rtl/combo_lock_top.sv
module combo_lock_top
  import combo_lock_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               enter,
  input  logic [DIGIT_W-1:0] entry,
  input  logic [DIGIT_W-1:0] code0,
  input  logic [DIGIT_W-1:0] code1,
  input  logic [DIGIT_W-1:0] code2,
  output logic [NUM_DIGITS-1:0] digit_sel,
  output logic               unlocked
);
  logic [STATE_W-1:0] state;
  logic [DIGIT_W-1:0] expected;
  logic               match;

  digit_select #(.DW(DIGIT_W), .ND(NUM_DIGITS)) u_sel (
    .sel(state[NUM_DIGITS-1:0]),
    .codes({code2, code1, code0}),
    .picked(expected)
  );

  digit_compare #(.DW(DIGIT_W)) u_cmp (
    .a(entry),
    .b(expected),
    .match(match)
  );

  lock_fsm #(.ND(NUM_DIGITS)) u_fsm (
    .clk(clk),
    .rst(rst),
    .enter(enter),
    .match(match),
    .state(state)
  );

  assign digit_sel = state[NUM_DIGITS-1:0];
  assign unlocked  = state[STATE_W-1];

  // R6
  open_excl_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> digit_sel == '0);
  // R7
  open_stay_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked);
endmodule

// File: tb/tb_combo_lock_top.sv
module tb_combo_lock_top;
  logic clk = 0, rst = 1, enter = 0;
  logic [3:0] entry = 0;
  logic [3:0] code0 = 4'h3, code1 = 4'hA, code2 = 4'h6;
  logic [2:0] digit_sel;
  logic unlocked;
  int checks = 0, fails = 0;
  bit done = 0;

  combo_lock_top dut (.clk(clk), .rst(rst), .enter(enter), .entry(entry),
    .code0(code0), .code1(code1), .code2(code2),
    .digit_sel(digit_sel), .unlocked(unlocked));

  always #2 clk = ~clk;

  task automatic check(string req, logic [2:0] esel, logic eopen);
    checks++;
    if (digit_sel !== esel || unlocked !== eopen) begin
      fails++;
      $display("FAIL %s: sel=%b open=%b expected sel=%b open=%b",
               req, digit_sel, unlocked, esel, eopen);
    end
  endtask

  task automatic tick(logic e, logic [3:0] v);
    @(negedge clk); enter = e; entry = v;
    @(negedge clk); enter = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    do_reset(); check("R1", 3'b001, 0);
    tick(1, code0); check("R3", 3'b010, 0);
    @(negedge clk); rst = 1; enter = 1; entry = code1;
    @(negedge clk); rst = 0; enter = 0;
    check("R1", 3'b001, 0);
  endtask

  task automatic t_open();
    do_reset();
    tick(1, code0); check("R3", 3'b010, 0);
    repeat (3) @(negedge clk); check("R2", 3'b010, 0);
    tick(1, code1); check("R5", 3'b100, 0);
    repeat (2) @(negedge clk); check("R2", 3'b100, 0);
    tick(1, code2); check("R6", 3'b000, 1);
    tick(1, 4'h0); check("R7", 3'b000, 1);
    tick(1, code0); check("R7", 3'b000, 1);
    do_reset(); check("R1", 3'b001, 0);
  endtask

  task automatic t_wrong_last();
    do_reset();
    tick(1, code0); tick(1, code1);
    tick(1, code2 ^ 4'h1); check("R4", 3'b000, 0);
    tick(1, code0); check("R7", 3'b000, 0);
    tick(1, code2); check("R7", 3'b000, 0);
  endtask

  task automatic t_bits();
    for (int b = 0; b < 4; b++) begin
      do_reset();
      tick(1, code0 ^ (4'h1 << b)); check("R8", 3'b000, 0);
    end
    for (int b = 0; b < 4; b++) begin
      do_reset(); tick(1, code0);
      tick(1, code1 ^ (4'h1 << b)); check("R8", 3'b000, 0);
    end
  endtask

  task automatic t_other_code();
    code0 = 4'hF; code1 = 4'h0; code2 = 4'hF;
    do_reset();
    tick(1, 4'hF); tick(1, 4'h0); tick(1, 4'hF); check("R3", 3'b000, 1);
    do_reset();
    tick(1, 4'h0); check("R4", 3'b000, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset(); t_open(); t_wrong_last(); t_bits(); t_other_code();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk);
        checks++; fails++; $display("FAIL watchdog: actual hung expected done"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule